// File: doc/BRIEF.md
# Ring Privilege and Gate Check Unit

This unit decides whether a segment-register load, a verify or adjust operation, or a far control transfer may go ahead under four-ring protection. Each request carries the current ring, the requestor level of the selector, the target descriptor's level and type bits, an optional gate level and parameter count, the level of the new stack segment and a reference level. The unit returns one registered verdict: allowed, general-protection fault or stack fault. It also returns the ring the processor runs at afterwards, the stack slot and parameter copy count for a transfer that raises privilege, a zero-flag result and an adjusted requestor level.

Levels are 2-bit numbers: 0 is the most trusted ring and 3 the least. Fetching descriptors, range-checking offsets and copying stack contents are left to neighbouring logic. Only the bit that says whether the selector lay inside its descriptor table reaches this unit.

Top module: `priv_gate_check`

## Requirements
- R1: After reset, res_valid, allow, gp_fault, stack_fault, zf and interlevel are low. A request with op_valid high in one cycle produces res_valid high with its verdict in the next cycle. A cycle with op_valid low leaves res_valid low in the following cycle.
- R2: The data load (op_code 0) is allowed only when the descriptor is in bounds and, for a data descriptor, desc_dpl >= max(cur_pl, sel_rpl). Otherwise it raises gp_fault.
- R3: A code descriptor read as data (op_code 0 or 6) must have its read bit set. If its conforming bit is set, its level is not checked. A code descriptor is never writable, whatever its write bit says: stack load faults and verify-write returns zf low.
- R4: The stack load (op_code 1) is allowed only for an in-bounds writable data descriptor with desc_dpl == cur_pl and sel_rpl == cur_pl. Otherwise it raises gp_fault.
- R5: A direct far jump (op_code 2) or far call (op_code 3) needs an in-bounds code target. A nonconforming target needs desc_dpl == cur_pl and a conforming target needs desc_dpl <= cur_pl. Otherwise gp_fault is raised. new_pl stays cur_pl and interlevel stays low.
- R6: A jump through a gate (op_code 4) needs max(cur_pl, sel_rpl) <= gate_dpl in addition to the rule of R5. It never changes the ring.
- R7: A call through a gate (op_code 5) needs max(cur_pl, sel_rpl) <= gate_dpl and an in-bounds code target with desc_dpl <= cur_pl. If the target is nonconforming and desc_dpl < cur_pl, the call is interlevel: interlevel is high and new_pl and stack_slot both equal desc_dpl, which is never 3. In every other case new_pl is cur_pl.
- R8: On an interlevel call, stk_dpl must equal desc_dpl. If it does not, stack_fault is raised (not gp_fault) and allow is low. copy_count equals the 5-bit gate_count (0 to 31) on an allowed interlevel call and is 0 on every other result.
- R9: Verify-read (op_code 6) never faults. zf is high only for an in-bounds descriptor that is readable (every data descriptor, or a code descriptor with its read bit set) and either conforming code or desc_dpl >= max(cur_pl, sel_rpl).
- R10: Verify-write (op_code 7) never faults. zf is high only for an in-bounds data descriptor with its write bit set and desc_dpl >= max(cur_pl, sel_rpl).
- R11: Adjust (op_code 8) returns adj_rpl = max(sel_rpl, ref_rpl) and zf high only when ref_rpl > sel_rpl. It never faults and ignores desc_in_bounds. All other operations return adj_rpl = sel_rpl.
- R12: Op codes 9 to 15 raise gp_fault with zf low and new_pl equal to cur_pl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request present this cycle |
| op_code | input | 4 | Operation: 0 data load, 1 stack load, 2 far jump, 3 far call, 4 gate jump, 5 gate call, 6 verify-read, 7 verify-write, 8 adjust |
| cur_pl | input | 2 | Current privilege ring |
| sel_rpl | input | 2 | Requestor level of the selector |
| desc_dpl | input | 2 | Target descriptor level |
| desc_code | input | 1 | Target is a code descriptor |
| desc_conform | input | 1 | Code target is conforming |
| desc_read | input | 1 | Code target may be read |
| desc_write | input | 1 | Data target may be written |
| desc_in_bounds | input | 1 | Selector lay inside its table |
| gate_dpl | input | 2 | Level of the gate used |
| gate_count | input | 5 | Parameter doubleword count of the gate |
| stk_dpl | input | 2 | Level of the inner stack segment |
| ref_rpl | input | 2 | Reference level for adjust |
| res_valid | output | 1 | Verdict present |
| allow | output | 1 | Operation permitted |
| gp_fault | output | 1 | General-protection fault |
| stack_fault | output | 1 | Stack fault on inner stack level |
| zf | output | 1 | Zero-flag result for verify and adjust |
| new_pl | output | 2 | Ring after the operation |
| interlevel | output | 1 | Call moved to a more trusted ring |
| stack_slot | output | 2 | Stack pointer slot for the inner ring |
| copy_count | output | 5 | Doublewords to copy to the inner stack |
| adj_rpl | output | 2 | Adjusted requestor level |

## Verification
A wrong comparison in the level arithmetic shows up one cycle after the request. It appears as a flipped allow/gp_fault pair or a wrong zf, and it shows only for level combinations near the boundary of the rule: equal levels, or a max taken from the wrong operand. A mistake in interlevel detection shows in the same cycle as a wrong new_pl, stack_slot or copy_count, or as a stack fault reported as a general-protection fault. Because the output register is reloaded on every request, no wrong state survives beyond the next accepted request. Stimulus therefore has to cover every level tuple in each operation, not merely run for a long time.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int PL_W  = 2;
  localparam int CNT_W = 5;
  localparam int OP_W  = 4;
  localparam int PL_TOP = (1 << PL_W) - 1;

  typedef logic [PL_W-1:0]  pl_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [OP_W-1:0] {
    OP_DATA_LD   = 4'd0,
    OP_STACK_LD  = 4'd1,
    OP_JMP_FAR   = 4'd2,
    OP_CALL_FAR  = 4'd3,
    OP_JMP_GATE  = 4'd4,
    OP_CALL_GATE = 4'd5,
    OP_VFY_RD    = 4'd6,
    OP_VFY_WR    = 4'd7,
    OP_ADJ_RPL   = 4'd8
  } op_e;

  typedef struct packed {
    logic code;
    logic conform;
    logic rd;
    logic wr;
    logic in_bounds;
    pl_t  dpl;
  } desc_t;

  typedef struct packed {
    logic gp;
    logic sf;
    logic zf;
    pl_t  new_pl;
    logic inter;
    pl_t  slot;
    cnt_t cnt;
    pl_t  adj;
  } verdict_t;

  // Numerically larger level, i.e. the less trusted of the two.
  function automatic pl_t pl_max(input pl_t a, input pl_t b);
    return (a > b) ? a : b;
  endfunction

  // Target level is at least as untrusted as both the ring and the requestor.
  function automatic logic level_visible(input pl_t tgt, input pl_t cpl, input pl_t rpl);
    return tgt >= pl_max(cpl, rpl);
  endfunction

  // Rule for a code target reached without raising privilege.
  function automatic logic code_same_ring(input pl_t tgt, input pl_t cpl, input logic conf);
    return conf ? (tgt <= cpl) : (tgt == cpl);
  endfunction

  function automatic verdict_t verdict_idle(input pl_t cpl, input pl_t rpl);
    verdict_t v;
    v = '0;
    v.new_pl = cpl;
    v.adj = rpl;
    return v;
  endfunction
endpackage

// File: rtl/pgc_data_rules.sv
module pgc_data_rules
  import pgc_pkg::*;
(
  input  op_e      op,
  input  pl_t      cpl,
  input  pl_t      rpl,
  input  desc_t    d,
  output verdict_t v
);
  logic vis;
  logic rd_ok;
  logic rd_priv;
  logic wr_ok;

  assign vis     = level_visible(d.dpl, cpl, rpl);
  assign rd_ok   = !d.code || d.rd;
  assign rd_priv = (d.code && d.conform) || vis;
  assign wr_ok   = !d.code && d.wr;

  always_comb begin
    v = verdict_idle(cpl, rpl);
    unique case (op)
      OP_DATA_LD:  v.gp = !(d.in_bounds && rd_ok && rd_priv);
      OP_STACK_LD: v.gp = !(d.in_bounds && wr_ok && (d.dpl == cpl) && (rpl == cpl));
      OP_VFY_RD:   v.zf = d.in_bounds && rd_ok && rd_priv;
      OP_VFY_WR:   v.zf = d.in_bounds && wr_ok && vis;
      default:     v.gp = 1'b1;
    endcase
  end
endmodule

// File: rtl/pgc_xfer_rules.sv
module pgc_xfer_rules
  import pgc_pkg::*;
(
  input  op_e      op,
  input  pl_t      cpl,
  input  pl_t      rpl,
  input  pl_t      tgt_dpl,
  input  logic     tgt_code,
  input  logic     tgt_conform,
  input  logic     tgt_in_bounds,
  input  pl_t      gate_dpl,
  input  cnt_t     gate_count,
  input  pl_t      stk_dpl,
  output logic     lower_call,
  output verdict_t v
);
  logic via_gate;
  logic gate_ok;
  logic tgt_ok;
  logic priv_ok;

  assign via_gate = (op == OP_JMP_GATE) || (op == OP_CALL_GATE);
  assign gate_ok  = pl_max(cpl, rpl) <= gate_dpl;
  assign tgt_ok   = (op == OP_CALL_GATE) ? (tgt_dpl <= cpl)
                                         : code_same_ring(tgt_dpl, cpl, tgt_conform);
  assign priv_ok  = tgt_in_bounds && tgt_code && tgt_ok && (!via_gate || gate_ok);
  assign lower_call = priv_ok && (op == OP_CALL_GATE) && !tgt_conform && (tgt_dpl < cpl);

  always_comb begin
    v = verdict_idle(cpl, rpl);
    v.gp = !priv_ok;
    if (lower_call) begin
      if (stk_dpl != tgt_dpl) begin
        v.sf = 1'b1;
      end else begin
        v.inter  = 1'b1;
        v.new_pl = tgt_dpl;
        v.slot   = tgt_dpl;
        v.cnt    = gate_count;
      end
    end
  end
endmodule

// File: rtl/pgc_adjust.sv
module pgc_adjust
  import pgc_pkg::*;
(
  input  pl_t      cpl,
  input  pl_t      rpl,
  input  pl_t      ref_lvl,
  output verdict_t v
);
  always_comb begin
    v = verdict_idle(cpl, rpl);
    v.adj = pl_max(rpl, ref_lvl);
    v.zf  = ref_lvl > rpl;
  end
endmodule

// File: rtl/priv_gate_check.sv
module priv_gate_check
  import pgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [3:0] op_code,
  input  logic [1:0] cur_pl,
  input  logic [1:0] sel_rpl,
  input  logic [1:0] desc_dpl,
  input  logic       desc_code,
  input  logic       desc_conform,
  input  logic       desc_read,
  input  logic       desc_write,
  input  logic       desc_in_bounds,
  input  logic [1:0] gate_dpl,
  input  logic [4:0] gate_count,
  input  logic [1:0] stk_dpl,
  input  logic [1:0] ref_rpl,
  output logic       res_valid,
  output logic       allow,
  output logic       gp_fault,
  output logic       stack_fault,
  output logic       zf,
  output logic [1:0] new_pl,
  output logic       interlevel,
  output logic [1:0] stack_slot,
  output logic [4:0] copy_count,
  output logic [1:0] adj_rpl
);
  op_e      op_in;
  desc_t    desc;
  verdict_t v_data, v_xfer, v_adj, v_sel;
  logic     lower_call;
  logic     is_data_op, is_xfer_op, is_adj_op;

  assign op_in = op_e'(op_code);
  assign desc  = '{code: desc_code, conform: desc_conform, rd: desc_read,
                   wr: desc_write, in_bounds: desc_in_bounds, dpl: desc_dpl};

  assign is_data_op = (op_in == OP_DATA_LD) || (op_in == OP_STACK_LD) ||
                      (op_in == OP_VFY_RD)  || (op_in == OP_VFY_WR);
  assign is_xfer_op = (op_in == OP_JMP_FAR)  || (op_in == OP_CALL_FAR) ||
                      (op_in == OP_JMP_GATE) || (op_in == OP_CALL_GATE);
  assign is_adj_op  = (op_in == OP_ADJ_RPL);

  pgc_data_rules u_data (
    .op(op_in), .cpl(cur_pl), .rpl(sel_rpl), .d(desc), .v(v_data)
  );

  pgc_xfer_rules u_xfer (
    .op(op_in), .cpl(cur_pl), .rpl(sel_rpl), .tgt_dpl(desc_dpl),
    .tgt_code(desc_code), .tgt_conform(desc_conform), .tgt_in_bounds(desc_in_bounds),
    .gate_dpl(gate_dpl), .gate_count(gate_count), .stk_dpl(stk_dpl),
    .lower_call(lower_call), .v(v_xfer)
  );

  pgc_adjust u_adj (
    .cpl(cur_pl), .rpl(sel_rpl), .ref_lvl(ref_rpl), .v(v_adj)
  );

  always_comb begin
    if (is_data_op)      v_sel = v_data;
    else if (is_xfer_op) v_sel = v_xfer;
    else if (is_adj_op)  v_sel = v_adj;
    else begin
      v_sel    = verdict_idle(cur_pl, sel_rpl);
      v_sel.gp = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      allow       <= 1'b0;
      gp_fault    <= 1'b0;
      stack_fault <= 1'b0;
      zf          <= 1'b0;
      new_pl      <= '0;
      interlevel  <= 1'b0;
      stack_slot  <= '0;
      copy_count  <= '0;
      adj_rpl     <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        allow       <= !(v_sel.gp || v_sel.sf);
        gp_fault    <= v_sel.gp;
        stack_fault <= v_sel.sf;
        zf          <= v_sel.zf;
        new_pl      <= v_sel.new_pl;
        interlevel  <= v_sel.inter;
        stack_slot  <= v_sel.slot;
        copy_count  <= v_sel.cnt;
        adj_rpl     <= v_sel.adj;
      end
    end
  end

  // R1: verdict follows a request by one cycle, idle cycles give no verdict.
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  a_r1_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0({gp_fault, stack_fault}));

  // R2: data descriptor below the effective level is refused.
  a_r2_data_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_in == OP_DATA_LD && !desc_code &&
     desc_dpl < pl_max(cur_pl, sel_rpl)) |=> gp_fault);

  // R3: code is never reported writable.
  a_r3_code_not_writable: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_in == OP_VFY_WR && desc_code) |=> !zf);

  // R5: direct transfers keep the ring.
  a_r5_direct_keeps_pl: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_in == OP_JMP_FAR || op_in == OP_CALL_FAR)) |=>
    (new_pl == $past(cur_pl) && !interlevel));

  // R6: gate jumps never move the ring.
  a_r6_gate_jmp_keeps_pl: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_in == OP_JMP_GATE) |=> (new_pl == $past(cur_pl) && !interlevel));

  // R7: a privilege-raising call ends as interlevel or as a stack fault.
  a_r7_lower_resolves: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && lower_call) |=> (interlevel || stack_fault));
  a_r7_inner_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && interlevel) |-> (new_pl != 2'(PL_TOP) && stack_slot == new_pl));

  // R8: parameters are copied only for an allowed interlevel call.
  a_r8_count_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !interlevel) |-> copy_count == '0);

  // R9 / R10: verify operations never fault.
  a_r9_verify_nofault: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_in == OP_VFY_RD || op_in == OP_VFY_WR)) |=>
    (!gp_fault && !stack_fault && allow));

  // R11: adjusted level is never more trusted than either input.
  a_r11_adj_not_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_in == OP_ADJ_RPL) |=>
    (adj_rpl >= $past(sel_rpl) && adj_rpl >= $past(ref_rpl) && allow));

  // R12: undefined codes fault.
  a_r12_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code > 4'd8) |=> (gp_fault && !zf));
endmodule

// File: tb/priv_gate_check_test.sv
module priv_gate_check_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [1:0] cur_pl = '0, sel_rpl = '0, desc_dpl = '0, gate_dpl = '0, stk_dpl = '0, ref_rpl = '0;
  logic       desc_code = 1'b0, desc_conform = 1'b0, desc_read = 1'b0, desc_write = 1'b0;
  logic       desc_in_bounds = 1'b0;
  logic [4:0] gate_count = '0;
  logic       res_valid, allow, gp_fault, stack_fault, zf, interlevel;
  logic [1:0] new_pl, stack_slot, adj_rpl;
  logic [4:0] copy_count;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  priv_gate_check uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cur_pl(cur_pl), .sel_rpl(sel_rpl), .desc_dpl(desc_dpl), .desc_code(desc_code),
    .desc_conform(desc_conform), .desc_read(desc_read), .desc_write(desc_write),
    .desc_in_bounds(desc_in_bounds), .gate_dpl(gate_dpl), .gate_count(gate_count),
    .stk_dpl(stk_dpl), .ref_rpl(ref_rpl), .res_valid(res_valid), .allow(allow),
    .gp_fault(gp_fault), .stack_fault(stack_fault), .zf(zf), .new_pl(new_pl),
    .interlevel(interlevel), .stack_slot(stack_slot), .copy_count(copy_count),
    .adj_rpl(adj_rpl)
  );

  // Packed expected result: valid, allow, gp, sf, zf, new_pl, inter, slot, count, adj
  function automatic logic [18:0] expect_of(
      input logic [3:0] op, input logic [1:0] cpl, input logic [1:0] rpl,
      input logic [1:0] dpl, input logic code, input logic conf, input logic rd,
      input logic wr, input logic inb, input logic [1:0] gdpl, input logic [4:0] cnt,
      input logic [1:0] sdpl, input logic [1:0] rref);
    logic [1:0] eff, npl, slot, adj;
    logic gp, sf, z, il, ok;
    logic [4:0] c;
    eff = (rpl > cpl) ? rpl : cpl;
    npl = cpl; adj = rpl; slot = 2'd0; c = 5'd0;
    gp = 1'b0; sf = 1'b0; z = 1'b0; il = 1'b0;
    if (op == 4'd0) begin
      if (code) ok = inb && rd && (conf || dpl >= eff);
      else      ok = inb && dpl >= eff;
      gp = !ok;
    end else if (op == 4'd1) begin
      gp = !(inb && !code && wr && dpl == cpl && rpl == cpl);
    end else if (op >= 4'd2 && op <= 4'd4) begin
      ok = inb && code && (conf ? dpl <= cpl : dpl == cpl);
      if (op == 4'd4) ok = ok && (eff <= gdpl);
      gp = !ok;
    end else if (op == 4'd5) begin
      ok = inb && code && dpl <= cpl && eff <= gdpl;
      gp = !ok;
      if (ok && !conf && dpl < cpl) begin
        if (sdpl == dpl) begin il = 1'b1; npl = dpl; slot = dpl; c = cnt; end
        else sf = 1'b1;
      end
    end else if (op == 4'd6) begin
      if (code) z = inb && rd && (conf || dpl >= eff);
      else      z = inb && dpl >= eff;
    end else if (op == 4'd7) begin
      z = inb && !code && wr && dpl >= eff;
    end else if (op == 4'd8) begin
      adj = (rref > rpl) ? rref : rpl;
      z = rref > rpl;
    end else begin
      gp = 1'b1;
    end
    return {1'b1, !(gp || sf), gp, sf, z, npl, il, slot, c, adj};
  endfunction

  function automatic string tag_for(input logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1: return "R4";
      4'd2, 4'd3: return "R5";
      4'd4: return "R6";
      4'd5: return "R7";
      4'd6: return "R9";
      4'd7: return "R10";
      4'd8: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [18:0] observed();
    return {res_valid, allow, gp_fault, stack_fault, zf, new_pl, interlevel,
            stack_slot, copy_count, adj_rpl};
  endfunction

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (v,al,gp,sf,zf,npl,il,slot,cnt,adj)", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [3:0] op, input logic [1:0] cpl,
      input logic [1:0] rpl, input logic [1:0] dpl, input logic code, input logic conf,
      input logic rd, input logic wr, input logic inb, input logic [1:0] gdpl,
      input logic [4:0] cnt, input logic [1:0] sdpl, input logic [1:0] rref);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; cur_pl = cpl; sel_rpl = rpl; desc_dpl = dpl;
    desc_code = code; desc_conform = conf; desc_read = rd; desc_write = wr;
    desc_in_bounds = inb; gate_dpl = gdpl; gate_count = cnt; stk_dpl = sdpl; ref_rpl = rref;
    @(negedge clk);
    check(tag, observed(),
          expect_of(op, cpl, rpl, dpl, code, conf, rd, wr, inb, gdpl, cnt, sdpl, rref));
    op_valid = 1'b0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", observed(), 19'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle actual=%b expected=0", res_valid);
    end

    // R2: equal level passes, RPL above DPL fails, out of bounds fails
    run("R2 equal", 4'd0, 2'd1, 2'd1, 2'd1, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    run("R2 rpl", 4'd0, 2'd0, 2'd3, 2'd2, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    run("R2 bounds", 4'd0, 2'd0, 2'd0, 2'd3, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    // R3: conforming readable code at level 0 read from ring 3; unreadable code; writable-bit code
    run("R3 conform", 4'd0, 2'd3, 2'd3, 2'd0, 1, 1, 1, 0, 1, 0, 0, 0, 0);
    run("R3 unread", 4'd6, 2'd0, 2'd0, 2'd3, 1, 0, 0, 0, 1, 0, 0, 0, 0);
    run("R3 vwr", 4'd7, 2'd0, 2'd0, 2'd3, 1, 0, 1, 1, 1, 0, 0, 0, 0);
    run("R3 stack", 4'd1, 2'd2, 2'd2, 2'd2, 1, 0, 1, 1, 1, 0, 0, 2, 0);
    run("R4 ok", 4'd1, 2'd2, 2'd2, 2'd2, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    run("R4 rpl", 4'd1, 2'd2, 2'd3, 2'd2, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    run("R5 nonconf", 4'd2, 2'd2, 2'd2, 2'd1, 1, 0, 1, 0, 1, 0, 0, 0, 0);
    run("R5 conf", 4'd3, 2'd2, 2'd3, 2'd0, 1, 1, 1, 0, 1, 0, 0, 0, 0);
    run("R6 gate lo", 4'd4, 2'd1, 2'd3, 2'd1, 1, 0, 1, 0, 1, 2, 0, 0, 0);
    run("R6 gate ok", 4'd4, 2'd1, 2'd2, 2'd1, 1, 0, 1, 0, 1, 2, 0, 0, 0);
    run("R7 inner", 4'd5, 2'd3, 2'd3, 2'd0, 1, 0, 1, 0, 1, 3, 5'd31, 0, 0);
    run("R7 conform", 4'd5, 2'd3, 2'd1, 2'd1, 1, 1, 1, 0, 1, 3, 5'd7, 1, 0);
    run("R8 stackflt", 4'd5, 2'd2, 2'd2, 2'd1, 1, 0, 1, 0, 1, 2, 5'd4, 2, 0);
    run("R8 zerocnt", 4'd5, 2'd3, 2'd3, 2'd2, 1, 0, 1, 0, 1, 3, 5'd0, 2, 0);
    run("R9 data", 4'd6, 2'd3, 2'd1, 2'd3, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    run("R10 deny", 4'd7, 2'd1, 2'd3, 2'd2, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    run("R11 raise", 4'd8, 2'd0, 2'd1, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd3);
    run("R11 same", 4'd8, 2'd0, 2'd2, 2'd0, 0, 0, 0, 0, 1, 0, 0, 0, 2'd1);
    run("R12 op15", 4'd15, 2'd2, 2'd0, 2'd0, 0, 0, 0, 0, 1, 0, 0, 0, 0);

    void'($urandom(32'h5EED_0A11));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r1, r2;
      logic [3:0] op;
      r1 = $urandom();
      r2 = $urandom();
      op = (r1[3:0] > 4'd9) ? r1[3:0] - 4'd9 : r1[3:0];
      if (op == 4'd9) op = 4'd9 + {1'b0, r2[30:28]};
      run(tag_for(op), op, r1[5:4], r1[7:6], r1[9:8], r1[10], r1[11], r1[12], r1[13],
          (r1[16:14] != 3'd0), r1[18:17], r1[23:19], r1[25:24], r1[27:26]);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule